// File: doc/BRIEF.md
# Processor Status Flags and Branch Decision Unit

This unit keeps the condition state of a small 16-bit processor in one 8-bit status byte. It also decides whether a conditional branch is taken. It accepts flag candidates from the ALU and performs its own compare, which is a subtraction whose only effect is on the flags. It tests one of four branch conditions against the stored flags and gives a registered taken bit to the program-counter logic. The unit also owns the interrupt-enable bit: interrupt entry clears it and the return-from-interrupt operation sets it.

The control sequencer raises the flag-write strobe to record ALU flags. It raises the compare strobe, with both operands, to record compare flags. It raises the branch-evaluate strobe, with a branch kind, to ask for a branch decision one cycle later. All outputs come straight from registers.

Top module: `status_branch_unit`

## Requirements
- R1: The status byte holds carry in bit 0, overflow in bit 1, negative in bit 2, zero in bit 3, interrupt-enable in bit 4 and less-than in bit 5. Bits 6 and 7 always read 0. Each single-flag output equals its bit in the status byte.
- R2: A synchronous active-high reset clears every flag and the taken output.
- R3: When the ALU flag strobe is high, the next cycle shows carry and overflow copied from their candidate inputs, negative equal to the result MSB, and zero set when the result is all zeros. Less-than and interrupt-enable keep their values.
- R4: When the compare strobe is high, the unit computes first operand minus second operand. Zero is set when the operands are equal, and negative is the MSB of the difference. Carry is 1 when the first operand is below the second as unsigned numbers (a borrow). Overflow is the signed overflow of the subtraction. Less-than is negative XOR overflow, which means the first operand is smaller as a signed number. Interrupt-enable is not affected.
- R5: When the compare strobe and the ALU flag strobe are high in the same cycle, the compare results are stored.
- R6: Branch kind is a 3-bit code. Code 0 is taken when zero is 1. Code 1 is taken when zero is 0. Code 2 is taken when less-than is 1. Code 3 is taken when less-than and zero are both 0. Codes 4 to 7 are never taken.
- R7: The taken output is high only in the cycle after a clock edge where the branch-evaluate strobe was high. The decision uses the flags as they stood before that edge, even if the same edge writes new flags.
- R8: The interrupt-entry pulse clears interrupt-enable and the return pulse sets it. When both come in the same cycle, the bit is cleared. Interrupt-enable changes at no other time.
- R9: With neither flag strobe high, carry, overflow, negative, zero and less-than keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alu_res | input | 16 | ALU result used for the negative and zero flags |
| alu_carry | input | 1 | Carry candidate from the ALU |
| alu_ovf | input | 1 | Overflow candidate from the ALU |
| flag_wr | input | 1 | Store the ALU flags |
| cmp_a | input | 16 | Compare first operand |
| cmp_b | input | 16 | Compare second operand |
| cmp_wr | input | 1 | Run a compare and store its flags |
| br_kind | input | 3 | Branch condition code |
| br_eval | input | 1 | Evaluate the branch condition |
| irq_enter | input | 1 | Interrupt entry pulse |
| irq_return | input | 1 | Return-from-interrupt pulse |
| status | output | 8 | Status byte |
| flag_c | output | 1 | Carry flag |
| flag_o | output | 1 | Overflow flag |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_ie | output | 1 | Interrupt-enable flag |
| flag_lt | output | 1 | Less-than flag |
| br_taken | output | 1 | Registered branch decision |

## Verification
The bench targets compares where the signed and unsigned orderings disagree, for example the most negative value against 1. A design that took less-than from the negative flag alone would branch the wrong way on that compare, and one that got borrow backwards would show the wrong carry.

A branch evaluation on the same edge as a flag write checks the ordering rule. A design that decided from the new flags would flip the taken bit. Equal operands check that greater-than is refused. Codes 4 to 7 catch a design that decodes only the low two bits.

Simultaneous strobes check the priorities: compare over ALU write, and entry over return. ALU writes that follow a compare check that less-than and interrupt-enable are left alone.

// File: rtl/sbu_pkg.sv
package sbu_pkg;
  localparam int STATUS_W = 8;
  localparam int BIT_C    = 0;
  localparam int BIT_O    = 1;
  localparam int BIT_N    = 2;
  localparam int BIT_Z    = 3;
  localparam int BIT_IE   = 4;
  localparam int BIT_LT   = 5;
  localparam int USED_W   = 6;
  localparam int KIND_W   = 3;

  typedef enum logic [KIND_W-1:0] {
    K_EQ = 3'd0,
    K_NE = 3'd1,
    K_LT = 3'd2,
    K_GT = 3'd3
  } br_kind_e;

  typedef struct packed {
    logic z;
    logic n;
    logic o;
    logic c;
  } cc_t;
endpackage

// File: rtl/sbu_flag_calc.sv
module sbu_flag_calc
  import sbu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] alu_res,
  input  logic              alu_carry,
  input  logic              alu_ovf,
  input  logic [DATA_W-1:0] cmp_a,
  input  logic [DATA_W-1:0] cmp_b,
  output cc_t               alu_cc,
  output cc_t               cmp_cc,
  output logic              cmp_lt
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0]   diff_ext;
  logic [DATA_W-1:0] diff;
  logic              borrow;
  logic              sovf;

  always_comb begin
    alu_cc.c = alu_carry;
    alu_cc.o = alu_ovf;
    alu_cc.n = alu_res[MSB];
    alu_cc.z = (alu_res == '0);
  end

  always_comb begin
    diff_ext = {1'b0, cmp_a} - {1'b0, cmp_b};
    diff     = diff_ext[MSB:0];
    borrow   = diff_ext[DATA_W];
    sovf     = (cmp_a[MSB] ^ cmp_b[MSB]) & (diff[MSB] ^ cmp_a[MSB]);
    cmp_cc.c = borrow;
    cmp_cc.o = sovf;
    cmp_cc.n = diff[MSB];
    cmp_cc.z = (diff == '0);
    cmp_lt   = diff[MSB] ^ sovf;
  end
endmodule

// File: rtl/sbu_status_reg.sv
module sbu_status_reg
  import sbu_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic flag_wr,
  input  logic cmp_wr,
  input  cc_t  alu_cc,
  input  cc_t  cmp_cc,
  input  logic cmp_lt,
  input  logic irq_enter,
  input  logic irq_return,
  output cc_t  cc_q,
  output logic lt_q,
  output logic ie_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cc_q <= '0;
      lt_q <= 1'b0;
      ie_q <= 1'b0;
    end else begin
      if (cmp_wr) begin
        cc_q <= cmp_cc;
        lt_q <= cmp_lt;
      end else if (flag_wr) begin
        cc_q <= alu_cc;
      end
      if (irq_enter)       ie_q <= 1'b0;
      else if (irq_return) ie_q <= 1'b1;
    end
  end

  p_ie_off_r8: assert property (@(posedge clk) disable iff (rst)
    irq_enter |=> !ie_q);
  p_ie_on_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_return && !irq_enter) |=> ie_q);
  p_ie_keep_r8: assert property (@(posedge clk) disable iff (rst)
    (!irq_enter && !irq_return) |=> $stable(ie_q));
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!flag_wr && !cmp_wr) |=> ($stable(cc_q) && $stable(lt_q)));
  p_lt_keep_r3: assert property (@(posedge clk) disable iff (rst)
    (flag_wr && !cmp_wr) |=> $stable(lt_q));
  p_cmp_wins_r5: assert property (@(posedge clk) disable iff (rst)
    cmp_wr |=> (cc_q == $past(cmp_cc)));
endmodule

// File: rtl/sbu_branch_eval.sv
module sbu_branch_eval
  import sbu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              br_eval,
  input  logic [KIND_W-1:0] br_kind,
  input  logic              flag_z,
  input  logic              flag_lt,
  output logic              taken_q
);
  logic cond;

  always_comb begin
    case (br_kind)
      K_EQ:    cond = flag_z;
      K_NE:    cond = !flag_z;
      K_LT:    cond = flag_lt;
      K_GT:    cond = !flag_lt && !flag_z;
      default: cond = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) taken_q <= 1'b0;
    else     taken_q <= br_eval && cond;
  end

  p_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !br_eval |=> !taken_q);
  p_bad_code_r6: assert property (@(posedge clk) disable iff (rst)
    (br_eval && br_kind > 3'd3) |=> !taken_q);
  p_eq_r6: assert property (@(posedge clk) disable iff (rst)
    (br_eval && br_kind == 3'd0) |=> (taken_q == $past(flag_z)));
  p_gt_r6: assert property (@(posedge clk) disable iff (rst)
    (br_eval && br_kind == 3'd3) |=> (taken_q == (!$past(flag_lt) && !$past(flag_z))));
endmodule

// File: rtl/status_branch_unit.sv
module status_branch_unit
  import sbu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] alu_res,
  input  logic              alu_carry,
  input  logic              alu_ovf,
  input  logic              flag_wr,
  input  logic [DATA_W-1:0] cmp_a,
  input  logic [DATA_W-1:0] cmp_b,
  input  logic              cmp_wr,
  input  logic [KIND_W-1:0] br_kind,
  input  logic              br_eval,
  input  logic              irq_enter,
  input  logic              irq_return,
  output logic [STATUS_W-1:0] status,
  output logic              flag_c,
  output logic              flag_o,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_ie,
  output logic              flag_lt,
  output logic              br_taken
);
  localparam int PAD_W = STATUS_W - USED_W;

  cc_t  alu_cc, cmp_cc, cc_q;
  logic cmp_lt, lt_q, ie_q;

  sbu_flag_calc #(.DATA_W(DATA_W)) u_calc (
    .alu_res   (alu_res),
    .alu_carry (alu_carry),
    .alu_ovf   (alu_ovf),
    .cmp_a     (cmp_a),
    .cmp_b     (cmp_b),
    .alu_cc    (alu_cc),
    .cmp_cc    (cmp_cc),
    .cmp_lt    (cmp_lt)
  );

  sbu_status_reg u_sreg (
    .clk        (clk),
    .rst        (rst),
    .flag_wr    (flag_wr),
    .cmp_wr     (cmp_wr),
    .alu_cc     (alu_cc),
    .cmp_cc     (cmp_cc),
    .cmp_lt     (cmp_lt),
    .irq_enter  (irq_enter),
    .irq_return (irq_return),
    .cc_q       (cc_q),
    .lt_q       (lt_q),
    .ie_q       (ie_q)
  );

  sbu_branch_eval u_br (
    .clk     (clk),
    .rst     (rst),
    .br_eval (br_eval),
    .br_kind (br_kind),
    .flag_z  (cc_q.z),
    .flag_lt (lt_q),
    .taken_q (br_taken)
  );

  assign status[BIT_C]  = cc_q.c;
  assign status[BIT_O]  = cc_q.o;
  assign status[BIT_N]  = cc_q.n;
  assign status[BIT_Z]  = cc_q.z;
  assign status[BIT_IE] = ie_q;
  assign status[BIT_LT] = lt_q;

  for (genvar g = 0; g < PAD_W; g++) begin : g_pad
    assign status[USED_W+g] = 1'b0;
  end

  assign flag_c  = cc_q.c;
  assign flag_o  = cc_q.o;
  assign flag_n  = cc_q.n;
  assign flag_z  = cc_q.z;
  assign flag_ie = ie_q;
  assign flag_lt = lt_q;

  p_lt_signed_r4: assert property (@(posedge clk) disable iff (rst)
    cmp_wr |=> (flag_lt == ($signed($past(cmp_a)) < $signed($past(cmp_b)))));
  p_zero_eq_r4: assert property (@(posedge clk) disable iff (rst)
    cmp_wr |=> (flag_z == ($past(cmp_a) == $past(cmp_b))));
endmodule

// File: tb/status_branch_unit_bench.sv
`timescale 1ns/1ps
module status_branch_unit_bench;
  localparam int W = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst = 1'b1;
  logic [W-1:0] alu_res = '0;
  logic         alu_carry = 1'b0, alu_ovf = 1'b0, flag_wr = 1'b0;
  logic [W-1:0] cmp_a = '0, cmp_b = '0;
  logic         cmp_wr = 1'b0;
  logic [2:0]   br_kind = '0;
  logic         br_eval = 1'b0, irq_enter = 1'b0, irq_return = 1'b0;
  logic [7:0]   status;
  logic         flag_c, flag_o, flag_n, flag_z, flag_ie, flag_lt, br_taken;

  status_branch_unit #(.DATA_W(W)) u_status_branch_unit (
    .clk(clk), .rst(rst), .alu_res(alu_res), .alu_carry(alu_carry),
    .alu_ovf(alu_ovf), .flag_wr(flag_wr), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .cmp_wr(cmp_wr), .br_kind(br_kind), .br_eval(br_eval),
    .irq_enter(irq_enter), .irq_return(irq_return), .status(status),
    .flag_c(flag_c), .flag_o(flag_o), .flag_n(flag_n), .flag_z(flag_z),
    .flag_ie(flag_ie), .flag_lt(flag_lt), .br_taken(br_taken)
  );

  typedef struct {
    logic [7:0] st;
    logic       tk;
    string      tag;
  } item_t;

  item_t q[$];
  int n_vec = 0;
  int n_bad = 0;
  logic m_c = 0, m_o = 0, m_n = 0, m_z = 0, m_i = 0, m_l = 0;

  function automatic logic cond_of(input logic [2:0] k);
    case (k)
      3'd0:    return m_z;
      3'd1:    return !m_z;
      3'd2:    return m_l;
      3'd3:    return !m_l && !m_z;
      default: return 1'b0;
    endcase
  endfunction

  task automatic cyc(input logic r, input logic fw, input logic [W-1:0] res,
                     input logic c, input logic o, input logic cw,
                     input logic [W-1:0] a, input logic [W-1:0] b,
                     input logic bev, input logic [2:0] bk,
                     input logic ent, input logic ret, input string tag);
    item_t it;
    logic tk;
    logic signed [W:0] sd;
    @(negedge clk);
    rst = r; flag_wr = fw; alu_res = res; alu_carry = c; alu_ovf = o;
    cmp_wr = cw; cmp_a = a; cmp_b = b; br_eval = bev; br_kind = bk;
    irq_enter = ent; irq_return = ret;
    if (r) begin
      {m_c, m_o, m_n, m_z, m_i, m_l} = '0;
      tk = 1'b0;
    end else begin
      tk = bev && cond_of(bk);
      if (cw) begin
        sd  = $signed({a[W-1], a}) - $signed({b[W-1], b});
        m_c = (a < b);
        m_z = (a == b);
        m_n = sd[W-1];
        m_o = (sd[W] != sd[W-1]);
        m_l = ($signed(a) < $signed(b));
      end else if (fw) begin
        m_c = c; m_o = o; m_n = res[W-1]; m_z = (res == '0);
      end
      if (ent)      m_i = 1'b0;
      else if (ret) m_i = 1'b1;
    end
    it.st  = {2'b00, m_l, m_i, m_z, m_n, m_o, m_c};
    it.tk  = tk;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, '0, 0, 0, 0, '0, '0, 0, 3'd0, 0, 0, tag);
  endtask
  task automatic alu(input logic [W-1:0] res, input logic c, input logic o, input string tag);
    cyc(0, 1, res, c, o, 0, '0, '0, 0, 3'd0, 0, 0, tag);
  endtask
  task automatic cmp(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    cyc(0, 0, '0, 0, 0, 1, a, b, 0, 3'd0, 0, 0, tag);
  endtask
  task automatic br(input logic [2:0] k, input string tag);
    cyc(0, 0, '0, 0, 0, 0, '0, '0, 1, k, 0, 0, tag);
  endtask

  // Monitor: samples 1 ns after each rising edge
  always @(posedge clk) begin
    item_t it;
    #1;
    if (q.size() > 0) begin
      it = q.pop_front();
      n_vec++;
      if (status !== it.st || br_taken !== it.tk) begin
        n_bad++;
        $display("FAIL %s: status=%h taken=%b expected status=%h taken=%b",
                 it.tag, status, br_taken, it.st, it.tk);
      end
      if ({flag_lt, flag_ie, flag_z, flag_n, flag_o, flag_c} !== it.st[5:0]) begin
        n_bad++;
        $display("FAIL R1 (%s): flags=%b expected %b", it.tag,
                 {flag_lt, flag_ie, flag_z, flag_n, flag_o, flag_c}, it.st[5:0]);
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    cyc(1, 1, 16'hFFFF, 1, 1, 1, 16'h1, 16'h2, 1, 3'd1, 0, 1, "R2 reset");
    cyc(1, 0, '0, 0, 0, 0, '0, '0, 0, 3'd0, 0, 0, "R2 reset");
    idle("R2 after reset");
    alu(16'h0000, 1, 0, "R3 alu zero result");
    // branch evaluated on the same edge as a flag rewrite: old z=1 decides
    cyc(0, 1, 16'h8000, 0, 1, 0, '0, '0, 1, 3'd0, 0, 0, "R7 eq uses old flags");
    idle("R9 hold");
    br(3'd1, "R6 ne taken");
    br(3'd0, "R6 eq not taken");
    cmp(16'd5, 16'd7, "R4 5-7 borrow");
    br(3'd2, "R6 lt taken");
    br(3'd3, "R6 gt not taken");
    alu(16'h0001, 0, 0, "R3 lt kept by alu write");
    cmp(16'h8000, 16'h0001, "R4 signed overflow");
    br(3'd2, "R6 lt after overflow");
    cmp(16'd7, 16'd7, "R4 equal");
    br(3'd3, "R6 gt refused when equal");
    br(3'd0, "R6 eq taken");
    cmp(16'd9, 16'd3, "R4 greater");
    br(3'd3, "R6 gt taken");
    for (int k = 4; k < 8; k++) br(3'(k), "R6 unused code");
    cmp(16'd7, 16'd7, "R4 equal");
    for (int k = 4; k < 8; k++) br(3'(k), "R6 unused code with z=1");
    cyc(0, 1, 16'h1234, 1, 1, 1, 16'd1, 16'd2, 0, 3'd0, 0, 0, "R5 compare wins");
    cyc(0, 0, '0, 0, 0, 0, '0, '0, 0, 3'd0, 0, 1, "R8 return sets ie");
    cmp(16'd3, 16'd3, "R4 ie untouched");
    alu(16'hFFFF, 1, 0, "R3 ie untouched");
    cyc(0, 0, '0, 0, 0, 0, '0, '0, 0, 3'd0, 1, 1, "R8 entry beats return");
    cyc(0, 0, '0, 0, 0, 0, '0, '0, 0, 3'd0, 0, 1, "R8 return again");
    cyc(0, 0, '0, 0, 0, 0, '0, '0, 0, 3'd0, 1, 0, "R8 entry clears");
    idle("R7 taken low when idle");
    for (int i = 0; i < 300; i++) begin
      cyc(0, 1'($urandom), 16'($urandom), 1'($urandom), 1'($urandom),
          1'($urandom), 16'($urandom), 16'($urandom), 1'($urandom),
          3'($urandom), ($urandom % 8) == 0, ($urandom % 6) == 0, "R1-mix random R4 R6");
    end
    @(posedge clk);
    #2;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule